// File: doc/BRIEF.md
# Packed Half-Precision Compare to Predicate File

This block takes two operands that each carry a number of 16-bit half-precision lanes (two by default). It compares every lane of A with the lane of B at the same position, and all lanes use one shared condition code. The lane results are folded into a single boolean, with either an all-lanes (AND) reduction or an any-lane (OR) reduction. That boolean is then combined with a second source predicate through a selectable logic operation. The source predicate is read from the block's own predicate file and can be inverted.

Each issued operation can write two entries of an 8-entry predicate file. The primary entry gets the combined result. The secondary entry gets the same combination, except that the reduced comparison is inverted first. The top entry of the file is a constant true. It reads as 1, and every write to it is discarded, so the same index also serves as the "no secondary destination" marker. The lanes arrive already formatted, so selecting, negating or taking the absolute value of operands is done upstream. The whole file is exposed on one output vector, and writes become visible one clock after issue.

Top module: `hpair_cmp_pred`

## Requirements
- R1: While `rst_n` is low, predicate entries 0 to 6 are cleared to 0. After reset, `preds` reads 8'h80 until the first issue.
- R2: Each lane compares A to B using `cond[2:0]`: 0 never, 1 less, 2 equal, 3 less-or-equal, 4 greater, 5 not-equal, 6 greater-or-equal, 7 always. Lane k occupies bits [16k+15:16k].
- R3: A lane holding a NaN (exponent all ones, nonzero mantissa) in either operand makes codes 1 to 6 false when `cond[3]`=0 (ordered) and true when `cond[3]`=1 (unordered). +0 and -0 compare equal. Infinities order as the extreme values.
- R4: When `lane_all`=1 the lane results are reduced by AND. When `lane_all`=0 they are reduced by OR.
- R5: The second predicate is `preds[src_idx]` taken before the current write, XORed with `src_neg`. Index 7 reads as 1.
- R6: `comb_op` selects the combine: 0 AND, 1 OR, 2 XOR, and 3 behaves as AND.
- R7: On a cycle with `issue`=1, entry `dst_pri` takes (reduced compare) OP (second predicate) at the next clock edge.
- R8: On issue, entry `dst_sec` takes (NOT reduced compare) OP (second predicate), unless `dst_sec`=7. When `dst_sec` equals `dst_pri`, the secondary value is the one stored.
- R9: Without `issue` the file does not change. On issue, only the addressed entries change.
- R10: Entry 7 always reads 1. A write to index 7, primary or secondary, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Perform compare and write this cycle |
| a_lanes | input | 32 | Operand A, lane 0 in the low half |
| b_lanes | input | 32 | Operand B, lane 0 in the low half |
| cond | input | 4 | Bit 3 unordered, bits 2:0 relation |
| lane_all | input | 1 | 1 = AND reduction, 0 = OR reduction |
| comb_op | input | 2 | Logic op with second predicate |
| src_idx | input | 3 | Second predicate index |
| src_neg | input | 1 | Invert second predicate |
| dst_pri | input | 3 | Primary destination index |
| dst_sec | input | 3 | Secondary destination index, 7 = none |
| preds | output | 8 | Whole predicate file, bit i = entry i |

## Verification
The entire predicate file appears on `preds`, so a wrong comparison, reduction or combine shows up in the addressed bit one edge after issue. A write that lands on the wrong entry, or a stray write, changes a bit that should have stayed put, and that is visible in the same cycle. A corrupted entry that nothing writes again stays visible until it is next used as a source predicate. At that point it also distorts the result of the following write. Priority mistakes between the two destinations only appear when both indices match, so those cases are driven directly.

// File: rtl/hpc_pkg.sv
package hpc_pkg;

   typedef enum logic [1:0] {
      LOP_AND  = 2'd0,
      LOP_OR   = 2'd1,
      LOP_XOR  = 2'd2,
      LOP_AND2 = 2'd3
   } lop_e;

   function automatic logic lop_apply(input lop_e op, input logic x, input logic y);
      case (op)
         LOP_OR:  return x | y;
         LOP_XOR: return x ^ y;
         default: return x & y;
      endcase
   endfunction

endpackage

// File: rtl/hpc_lane_cmp.sv
module hpc_lane_cmp #(
   parameter int FP_W  = 16,
   parameter int EXP_W = 5
) (
   input  logic [FP_W-1:0] a,
   input  logic [FP_W-1:0] b,
   input  logic [3:0]      cond,
   output logic            hit
);
   localparam int MAN_W = FP_W - 1 - EXP_W;

   logic a_nan, b_nan, both_zero, mag_lt, lt, eq, gt, rel;

   assign a_nan     = (&a[FP_W-2 -: EXP_W]) && (|a[MAN_W-1:0]);
   assign b_nan     = (&b[FP_W-2 -: EXP_W]) && (|b[MAN_W-1:0]);
   assign both_zero = ~|{a[FP_W-2:0], b[FP_W-2:0]};
   assign mag_lt    = a[FP_W-2:0] < b[FP_W-2:0];

   always_comb begin
      lt = 1'b0;
      eq = 1'b0;
      gt = 1'b0;
      if (both_zero) begin
         eq = 1'b1;
      end else if (a[FP_W-1] != b[FP_W-1]) begin
         lt = a[FP_W-1];
         gt = ~a[FP_W-1];
      end else if (a[FP_W-2:0] == b[FP_W-2:0]) begin
         eq = 1'b1;
      end else begin
         lt = a[FP_W-1] ? ~mag_lt : mag_lt;
         gt = ~lt;
      end
   end

   always_comb begin
      case (cond[2:0])
         3'd1:    rel = lt;
         3'd2:    rel = eq;
         3'd3:    rel = lt | eq;
         3'd4:    rel = gt;
         3'd5:    rel = lt | gt;
         3'd6:    rel = gt | eq;
         default: rel = 1'b0;
      endcase
   end

   always_comb begin
      if (cond[2:0] == 3'd0)      hit = 1'b0;
      else if (cond[2:0] == 3'd7) hit = 1'b1;
      else if (a_nan || b_nan)    hit = cond[3];
      else                        hit = rel;
   end

endmodule

// File: rtl/hpc_pred_logic.sv
module hpc_pred_logic
   import hpc_pkg::*;
#(
   parameter int LANES = 2
) (
   input  logic [LANES-1:0] hits,
   input  logic             all_mode,
   input  lop_e             op,
   input  logic             src,
   output logic             pri_val,
   output logic             sec_val
);
   logic reduced;

   assign reduced = all_mode ? (&hits) : (|hits);
   assign pri_val = lop_apply(op, reduced, src);
   assign sec_val = lop_apply(op, ~reduced, src);

endmodule

// File: rtl/hpc_pred_file.sv
module hpc_pred_file #(
   parameter int N     = 8,
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_a,
   input  logic [IDX_W-1:0] idx_a,
   input  logic             d_a,
   input  logic             we_b,
   input  logic [IDX_W-1:0] idx_b,
   input  logic             d_b,
   output logic [N-1:0]     bits
);
   for (genvar i = 0; i < N; i++) begin : g_ent
      if (i == N - 1) begin : g_const
         assign bits[i] = 1'b1;
      end else begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n)                                 bits[i] <= 1'b0;
            else if (we_b && idx_b == IDX_W'(i))        bits[i] <= d_b;
            else if (we_a && idx_a == IDX_W'(i))        bits[i] <= d_a;
         end
      end
   end

endmodule

// File: rtl/hpair_cmp_pred.sv
module hpair_cmp_pred
   import hpc_pkg::*;
#(
   parameter int FP_W   = 16,
   parameter int EXP_W  = 5,
   parameter int LANES  = 2,
   parameter int PRED_N = 8,
   localparam int IDX_W = $clog2(PRED_N),
   localparam int OP_W  = LANES * FP_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             issue,
   input  logic [OP_W-1:0]  a_lanes,
   input  logic [OP_W-1:0]  b_lanes,
   input  logic [3:0]       cond,
   input  logic             lane_all,
   input  logic [1:0]       comb_op,
   input  logic [IDX_W-1:0] src_idx,
   input  logic             src_neg,
   input  logic [IDX_W-1:0] dst_pri,
   input  logic [IDX_W-1:0] dst_sec,
   output logic [PRED_N-1:0] preds
);
   localparam logic [IDX_W-1:0] CONST_IDX = IDX_W'(PRED_N - 1);

   if (LANES < 1) begin : g_bad_lanes
      $error("LANES must be at least 1");
   end
   if (EXP_W < 2 || EXP_W > FP_W - 2) begin : g_bad_exp
      $error("EXP_W must leave room for sign and mantissa");
   end
   if (PRED_N < 2 || PRED_N != (1 << IDX_W)) begin : g_bad_pn
      $error("PRED_N must be a power of two of at least 2");
   end

   logic [LANES-1:0] hits;
   logic             src_val, pri_val, sec_val;

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      hpc_lane_cmp #(.FP_W(FP_W), .EXP_W(EXP_W)) u_cmp (
         .a    (a_lanes[k*FP_W +: FP_W]),
         .b    (b_lanes[k*FP_W +: FP_W]),
         .cond (cond),
         .hit  (hits[k])
      );
   end

   assign src_val = preds[src_idx] ^ src_neg;

   hpc_pred_logic #(.LANES(LANES)) u_logic (
      .hits     (hits),
      .all_mode (lane_all),
      .op       (lop_e'(comb_op)),
      .src      (src_val),
      .pri_val  (pri_val),
      .sec_val  (sec_val)
   );

   hpc_pred_file #(.N(PRED_N), .IDX_W(IDX_W)) u_file (
      .clk   (clk),
      .rst_n (rst_n),
      .we_a  (issue && dst_pri != CONST_IDX),
      .idx_a (dst_pri),
      .d_a   (pri_val),
      .we_b  (issue && dst_sec != CONST_IDX),
      .idx_b (dst_sec),
      .d_b   (sec_val),
      .bits  (preds)
   );

endmodule

// File: rtl/hpair_cmp_pred_chk.sv
module hpair_cmp_pred_chk #(
   parameter int PRED_N = 8,
   localparam int IDX_W = $clog2(PRED_N)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              issue,
   input logic [3:0]        cond,
   input logic [1:0]        comb_op,
   input logic [IDX_W-1:0]  src_idx,
   input logic              src_neg,
   input logic [IDX_W-1:0]  dst_pri,
   input logic [IDX_W-1:0]  dst_sec,
   input logic [PRED_N-1:0] preds
);
   localparam logic [IDX_W-1:0] CI = IDX_W'(PRED_N - 1);

   logic src_v;
   assign src_v = preds[src_idx] ^ src_neg;

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !issue |=> $stable(preds));

   p_xor_split_r8: assert property (@(posedge clk) disable iff (!rst_n)
      issue && comb_op == 2'd2 && dst_pri != CI && dst_sec != CI && dst_pri != dst_sec
      |=> preds[$past(dst_pri)] != preds[$past(dst_sec)]);

   p_and_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      issue && comb_op == 2'd0 && !src_v && dst_pri != CI && dst_pri != dst_sec
      |=> !preds[$past(dst_pri)]);

   p_or_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
      issue && comb_op == 2'd1 && src_v && dst_sec != CI
      |=> preds[$past(dst_sec)]);

   p_never_r2: assert property (@(posedge clk) disable iff (!rst_n)
      issue && cond[2:0] == 3'd0 && comb_op == 2'd0 && dst_pri != CI && dst_pri != dst_sec
      |=> !preds[$past(dst_pri)]);

   for (genvar i = 0; i < PRED_N; i++) begin : g_keep
      p_untouched_r9: assert property (@(posedge clk) disable iff (!rst_n)
         issue && dst_pri != IDX_W'(i) && dst_sec != IDX_W'(i) |=> $stable(preds[i]));
   end

endmodule

bind hpair_cmp_pred hpair_cmp_pred_chk #(.PRED_N(PRED_N)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .issue   (issue),
   .cond    (cond),
   .comb_op (comb_op),
   .src_idx (src_idx),
   .src_neg (src_neg),
   .dst_pri (dst_pri),
   .dst_sec (dst_sec),
   .preds   (preds)
);

// File: tb/hpair_cmp_pred_test.sv
module hpair_cmp_pred_test;

   typedef struct packed {
      logic [31:0] a;
      logic [31:0] b;
      logic [3:0]  c;
      logic        la;
      logic [1:0]  op;
      logic [2:0]  si;
      logic        sn;
      logic [2:0]  dp;
      logic [2:0]  ds;
      logic        er;
   } vec_t;

   // lanes packed {hi, lo}; NaN rows cover R3
   localparam vec_t VECS [16] = '{
      '{32'h3C003C00, 32'h40004000, 4'd1,  1'b1, 2'd0, 3'd7, 1'b0, 3'd0, 3'd1, 1'b1},
      '{32'h3C004000, 32'h40003C00, 4'd1,  1'b1, 2'd1, 3'd0, 1'b0, 3'd2, 3'd7, 1'b0},
      '{32'h3C004000, 32'h40003C00, 4'd1,  1'b0, 2'd2, 3'd1, 1'b0, 3'd3, 3'd4, 1'b1},
      '{32'h80000000, 32'h00008000, 4'd2,  1'b1, 2'd0, 3'd7, 1'b0, 3'd5, 3'd6, 1'b1},
      '{32'hBC00C000, 32'hC000BC00, 4'd4,  1'b1, 2'd1, 3'd5, 1'b1, 3'd0, 3'd7, 1'b0},
      '{32'h7E003C00, 32'h3C003C00, 4'd2,  1'b1, 2'd0, 3'd7, 1'b0, 3'd1, 3'd2, 1'b0},
      '{32'h7E003C00, 32'h3C003C00, 4'd10, 1'b1, 2'd0, 3'd7, 1'b0, 3'd1, 3'd2, 1'b1},
      '{32'h7E007E00, 32'h3C003C00, 4'd5,  1'b0, 2'd2, 3'd3, 1'b1, 3'd4, 3'd5, 1'b0},
      '{32'h7E007E00, 32'h3C003C00, 4'd13, 1'b1, 2'd2, 3'd4, 1'b0, 3'd6, 3'd0, 1'b1},
      '{32'h7C007C00, 32'h40004000, 4'd6,  1'b1, 2'd1, 3'd2, 1'b1, 3'd3, 3'd7, 1'b1},
      '{32'hC0003800, 32'hC0003800, 4'd3,  1'b1, 2'd0, 3'd7, 1'b1, 3'd2, 3'd3, 1'b1},
      '{32'h3C003C00, 32'h3C003C00, 4'd0,  1'b0, 2'd1, 3'd7, 1'b1, 3'd0, 3'd1, 1'b0},
      '{32'h7E007E00, 32'h7E007E00, 4'd7,  1'b1, 2'd2, 3'd7, 1'b0, 3'd1, 3'd0, 1'b1},
      '{32'h3C00BC00, 32'h3C00BC00, 4'd1,  1'b0, 2'd3, 3'd7, 1'b0, 3'd4, 3'd5, 1'b0},
      '{32'h7E003C00, 32'h3C003C00, 4'd15, 1'b1, 2'd0, 3'd7, 1'b0, 3'd6, 3'd7, 1'b1},
      '{32'h3C003C00, 32'h40004000, 4'd8,  1'b0, 2'd1, 3'd6, 1'b0, 3'd5, 3'd4, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue = 1'b0;
   logic [31:0] a_lanes = '0, b_lanes = '0;
   logic [3:0]  cond = '0;
   logic        lane_all = 1'b0;
   logic [1:0]  comb_op = '0;
   logic [2:0]  src_idx = '0, dst_pri = '0, dst_sec = '0;
   logic        src_neg = 1'b0;
   logic [7:0]  preds;

   logic [7:0]  sh = 8'h80;
   int          total = 0, bad = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   hpair_cmp_pred uut (
      .clk(clk), .rst_n(rst_n), .issue(issue), .a_lanes(a_lanes), .b_lanes(b_lanes),
      .cond(cond), .lane_all(lane_all), .comb_op(comb_op), .src_idx(src_idx),
      .src_neg(src_neg), .dst_pri(dst_pri), .dst_sec(dst_sec), .preds(preds)
   );

   function automatic logic op_fn(input logic [1:0] op, input logic x, input logic y);
      case (op)
         2'd1:    return x | y;
         2'd2:    return x ^ y;
         default: return x & y;
      endcase
   endfunction

   task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: preds=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic run(input vec_t v, input string tag);
      logic s, p, q;
      @(negedge clk);
      a_lanes = v.a; b_lanes = v.b; cond = v.c; lane_all = v.la; comb_op = v.op;
      src_idx = v.si; src_neg = v.sn; dst_pri = v.dp; dst_sec = v.ds; issue = 1'b1;
      s = sh[v.si] ^ v.sn;
      p = op_fn(v.op, v.er, s);
      q = op_fn(v.op, ~v.er, s);
      if (v.dp != 3'd7) sh[v.dp] = p;
      if (v.ds != 3'd7) sh[v.ds] = q;
      @(negedge clk);
      issue = 1'b0;
      check(preds, sh, tag);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: run did not complete");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(preds, 8'h80, "R1 reset value");
      rst_n = 1'b1;
      @(negedge clk);
      check(preds, 8'h80, "R1 after release");

      for (int i = 0; i < 16; i++)
         run(VECS[i], $sformatf("R2 R3 R4 R5 R6 R7 R8 vector %0d", i));

      // R9: no issue, fields set, nothing changes
      @(negedge clk);
      a_lanes = 32'h3C003C00; b_lanes = 32'h3C003C00; cond = 4'd7; comb_op = 2'd1;
      dst_pri = 3'd0; dst_sec = 3'd1; src_idx = 3'd7;
      repeat (2) @(negedge clk);
      check(preds, sh, "R9 idle no write");

      // R10: both destinations at 7, always-true compare
      run('{32'h3C003C00, 32'h3C003C00, 4'd7, 1'b1, 2'd1, 3'd7, 1'b0, 3'd7, 3'd7, 1'b1},
          "R10 write to 7 ignored");
      check(preds & 8'h80, 8'h80, "R10 entry 7 reads 1");

      // R8: same index, secondary wins (pri=1&1=1, sec=0&1=0)
      run('{32'h3C003C00, 32'h3C003C00, 4'd2, 1'b1, 2'd0, 3'd7, 1'b0, 3'd2, 3'd2, 1'b1},
          "R8 same index secondary wins");
      check({7'd0, preds[2]}, 8'd0, "R8 entry 2 holds secondary");

      // R5: negated constant source gives 0; OR with r=1 sets pri, sec=0
      run('{32'h00000000, 32'h80008000, 4'd6, 1'b1, 2'd1, 3'd7, 1'b1, 3'd3, 3'd4, 1'b1},
          "R3 R5 zero equality with negated const");

      // R1: reset mid-run clears
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      sh = 8'h80;
      check(preds, 8'h80, "R1 mid-run reset");

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule